// File: doc/BRIEF.md
# DMA Channel Link and Completion Controller

This block sits between a DMA loop engine and the channel arbiter. It keeps, for every channel, an enable for the hardware request line and a pending start. A pending start comes from a software start write or from a link trigger sent by another channel. The block merges these into one registered request vector for the arbiter.

The loop engine reports each finished inner loop with the channel number, the iteration count left after the decrement, and the starting count. An event whose count reaches zero marks the outer loop as exhausted. From these events the block fires link triggers, sets the completion, error and interrupt flags, turns off the hardware request enable when auto-stop is set, and asks for the next descriptor when descriptor chaining is on. The flag set of each channel clears by writing ones.

Link settings are held inside the block and are written through a small configuration port. The other per-descriptor controls come in as static per-channel vectors.

Top module: `dma_link_ctl`

## Requirements
- R1: A set-enable write with channel c lets `hw_req[c]` reach `req_vec[c]` from the next cycle. A clear-enable write stops it. When a set and a clear write for the same channel fall in the same cycle, the clear wins.
- R2: A software start write with channel c drives `req_vec[c]` high from the next cycle. It stays high until a loop event for channel c arrives.
- R3: Link kind 1 (minor) fires on loop events whose count is not exhausted. `link_pulse[target]` goes high for one cycle, one cycle after the event, and `req_vec[target]` rises one cycle after that. An exhausting event does not fire a minor link.
- R4: Link kind 2 (major) fires only on the exhausting event, with the same timing as R3. Kinds 0 and 3 never fire.
- R5: When `cont_mode` is 1 and channel c has a minor link to itself, a non-exhausting event on c keeps `req_vec[c]` high with no gap and raises no link pulse. When `cont_mode` is 0, the same event drops `req_vec[c]` for one cycle and sends a link pulse to c.
- R6: When `auto_stop[c]` is 1, an exhausting event on c clears the hardware request enable of c in the same update. `req_vec[c]` is then low while `hw_req[c]` stays high.
- R7: An exhausting event sets `done_flag[c]` on the next cycle.
- R8: `irq[c]` is set by an exhausting event when `ien_major[c]` is 1. It is also set by a non-exhausting event whose count equals the starting count divided by two (rounded down) when `ien_half[c]` is 1. Events that match neither condition leave it clear.
- R9: An error event sets `err_flag[c]`. It also sets `irq[c]` when `ien_err[c]` is 1.
- R10: When `sg_en[c]` is 1, an exhausting event on c looks at the chain address of c. If its low 5 bits are zero, `fetch_vld` pulses one cycle later with that address and `fetch_ch = c`. Otherwise there is no fetch and `err_flag[c]` is set.
- R11: A link configuration write to a channel whose `done_flag` is 1 is ignored.
- R12: A status clear write with channel c and mask clears the flags selected by the mask: bit0 clears done, bit1 clears error, bit2 clears interrupt. A flag that is set in the same cycle stays set.
- R13: After reset, `req_vec`, `link_pulse`, all flags, `irq` and `fetch_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NCH | Hardware request lines |
| cont_mode | input | 1 | Continuous self-link mode |
| set_req_we | input | 1 | Set-enable write strobe |
| set_req_ch | input | CW | Channel for set-enable |
| clr_req_we | input | 1 | Clear-enable write strobe |
| clr_req_ch | input | CW | Channel for clear-enable |
| swst_we | input | 1 | Software start strobe |
| swst_ch | input | CW | Channel to start |
| lnk_we | input | 1 | Link configuration write strobe |
| lnk_ch | input | CW | Channel being configured |
| lnk_kind | input | 2 | 0 none, 1 minor, 2 major |
| lnk_tgt | input | CW | Link target channel |
| auto_stop | input | NCH | Clear hardware enable on exhaustion |
| ien_major | input | NCH | Interrupt on exhaustion |
| ien_half | input | NCH | Interrupt at half count |
| ien_err | input | NCH | Interrupt on error |
| sg_en | input | NCH | Descriptor chaining enable |
| sg_addr | input | NCH*AW | Per-channel next-descriptor address |
| evt_vld | input | 1 | Loop event valid |
| evt_ch | input | CW | Loop event channel |
| evt_major | input | 1 | Count exhausted by this event |
| evt_citer | input | CNT_W | Count left after decrement |
| evt_biter | input | CNT_W | Starting count |
| err_vld | input | 1 | Error event valid |
| err_ch | input | CW | Error event channel |
| sclr_we | input | 1 | Status clear strobe |
| sclr_ch | input | CW | Channel to clear |
| sclr_mask | input | 3 | Write-1-to-clear mask |
| req_vec | output | NCH | Request vector to arbiter |
| link_pulse | output | NCH | Link trigger pulses |
| done_flag | output | NCH | Completion flags |
| err_flag | output | NCH | Error flags |
| irq | output | NCH | Interrupt lines (interrupt flags) |
| fetch_vld | output | 1 | Next-descriptor fetch request |
| fetch_ch | output | CW | Channel of the fetch |
| fetch_addr | output | AW | Descriptor address to fetch |

## Verification
A wrong link table, a wrong target or a wrong link kind shows up as a missing or misplaced `link_pulse`. This is visible one cycle after the loop event, and the request vector shows it one cycle after that. An enable or pending bit left in the wrong state shows up on `req_vec` at the next edge. This includes a gap where a continuous self-link should keep the request high. Flag faults show up on the done, error and interrupt outputs one cycle after the event or clear write. A bad alignment decision shows up as a stray or missing `fetch_vld`, together with the error flag of that same channel.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_MINOR = 2'd1,
    LK_MAJOR = 2'd2
  } link_kind_e;

  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
endpackage

// File: rtl/dlc_link.sv
module dlc_link #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cont_mode,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_kind,
  input  logic [CW-1:0]  cfg_tgt,
  input  logic [NCH-1:0] done_vec,
  input  logic           evt_vld,
  input  logic [CW-1:0]  evt_ch,
  input  logic           evt_major,
  output logic [NCH-1:0] link_pulse,
  output logic           self_hold
);
  import dlc_pkg::*;

  logic [1:0]    kind_q [NCH];
  logic [CW-1:0] tgt_q  [NCH];
  logic [1:0]    cur_kind;
  logic [CW-1:0] cur_tgt;
  logic          fire;
  logic [NCH-1:0] pulse_nxt;

  // link settings are frozen while the channel still shows completion
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin
        kind_q[k] <= LK_NONE;
        tgt_q[k]  <= '0;
      end
    end else if (cfg_we && !done_vec[cfg_ch]) begin
      kind_q[cfg_ch] <= cfg_kind;
      tgt_q[cfg_ch]  <= cfg_tgt;
    end
  end

  always_comb begin
    cur_kind  = kind_q[evt_ch];
    cur_tgt   = tgt_q[evt_ch];
    fire      = evt_vld && ((!evt_major && cur_kind == LK_MINOR) ||
                            (evt_major && cur_kind == LK_MAJOR));
    self_hold = fire && cont_mode && !evt_major && (cur_tgt == evt_ch);
    pulse_nxt = (fire && !self_hold) ? (NCH'(1) << cur_tgt) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) link_pulse <= '0;
    else     link_pulse <= pulse_nxt;
  end
endmodule

// File: rtl/dlc_req.sv
module dlc_req #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hw_req,
  input  logic           set_we,
  input  logic [CW-1:0]  set_ch,
  input  logic           clr_we,
  input  logic [CW-1:0]  clr_ch,
  input  logic           st_we,
  input  logic [CW-1:0]  st_ch,
  input  logic [NCH-1:0] link_pulse,
  input  logic           evt_vld,
  input  logic [CW-1:0]  evt_ch,
  input  logic           evt_major,
  input  logic [NCH-1:0] auto_stop,
  input  logic           self_hold,
  output logic [NCH-1:0] req_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic erq_r, pend_r, req_r;
    logic erq_n, pend_n;

    always_comb begin
      erq_n = erq_r;
      if (set_we && set_ch == CW'(i)) erq_n = 1'b1;
      if (evt_vld && evt_major && evt_ch == CW'(i) && auto_stop[i]) erq_n = 1'b0;
      if (clr_we && clr_ch == CW'(i)) erq_n = 1'b0;

      pend_n = pend_r;
      if (evt_vld && evt_ch == CW'(i) && !self_hold) pend_n = 1'b0;
      if (st_we && st_ch == CW'(i)) pend_n = 1'b1;
      if (link_pulse[i]) pend_n = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        erq_r  <= 1'b0;
        pend_r <= 1'b0;
        req_r  <= 1'b0;
      end else begin
        erq_r  <= erq_n;
        pend_r <= pend_n;
        req_r  <= (hw_req[i] && erq_n) || pend_n;
      end
    end

    assign req_vec[i] = req_r;
  end
endmodule

// File: rtl/dlc_stat.sv
module dlc_stat #(
  parameter int NCH   = 4,
  parameter int CW    = 2,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_vld,
  input  logic [CW-1:0]    evt_ch,
  input  logic             evt_major,
  input  logic [CNT_W-1:0] evt_citer,
  input  logic [CNT_W-1:0] evt_biter,
  input  logic             err_vld,
  input  logic [CW-1:0]    err_ch,
  input  logic             sg_err,
  input  logic [NCH-1:0]   ien_major,
  input  logic [NCH-1:0]   ien_half,
  input  logic [NCH-1:0]   ien_err,
  input  logic             sclr_we,
  input  logic [CW-1:0]    sclr_ch,
  input  logic [2:0]       sclr_mask,
  output logic [NCH-1:0]   done_vec,
  output logic [NCH-1:0]   err_vec,
  output logic [NCH-1:0]   int_vec
);
  import dlc_pkg::*;

  logic at_half;
  assign at_half = evt_vld && !evt_major && (evt_citer == (evt_biter >> 1));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic done_r, err_r, int_r;
    logic hit, maj, hf, er;
    logic [2:0] clr;

    always_comb begin
      hit = evt_vld && evt_ch == CW'(i);
      maj = hit && evt_major;
      hf  = hit && at_half;
      er  = (err_vld && err_ch == CW'(i)) || (sg_err && evt_ch == CW'(i));
      clr = (sclr_we && sclr_ch == CW'(i)) ? sclr_mask : 3'b000;
    end

    // a new set beats a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        done_r <= 1'b0;
        err_r  <= 1'b0;
        int_r  <= 1'b0;
      end else begin
        done_r <= maj || (done_r && !clr[ST_DONE]);
        err_r  <= er  || (err_r  && !clr[ST_ERR]);
        int_r  <= (maj && ien_major[i]) || (hf && ien_half[i]) ||
                  (er && ien_err[i]) || (int_r && !clr[ST_INT]);
      end
    end

    assign done_vec[i] = done_r;
    assign err_vec[i]  = err_r;
    assign int_vec[i]  = int_r;
  end
endmodule

// File: rtl/dlc_sg.sv
module dlc_sg #(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int AW  = 32,
  parameter int ALB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_vld,
  input  logic [CW-1:0]     evt_ch,
  input  logic              evt_major,
  input  logic [NCH-1:0]    sg_en,
  input  logic [NCH*AW-1:0] sg_addr,
  output logic              fetch_vld,
  output logic [CW-1:0]     fetch_ch,
  output logic [AW-1:0]     fetch_addr,
  output logic              sg_err
);
  logic [AW-1:0] cand;
  logic          go, aligned;

  always_comb begin
    cand    = sg_addr[evt_ch*AW +: AW];
    go      = evt_vld && evt_major && sg_en[evt_ch];
    aligned = (cand[ALB-1:0] == '0);
    sg_err  = go && !aligned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_vld  <= 1'b0;
      fetch_ch   <= '0;
      fetch_addr <= '0;
    end else begin
      fetch_vld <= go && aligned;
      if (go && aligned) begin
        fetch_ch   <= evt_ch;
        fetch_addr <= cand;
      end
    end
  end
endmodule

// File: rtl/dma_link_ctl.sv
module dma_link_ctl #(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int CNT_W = 9,
  parameter int ALB   = 5,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    hw_req,
  input  logic              cont_mode,
  input  logic              set_req_we,
  input  logic [CW-1:0]     set_req_ch,
  input  logic              clr_req_we,
  input  logic [CW-1:0]     clr_req_ch,
  input  logic              swst_we,
  input  logic [CW-1:0]     swst_ch,
  input  logic              lnk_we,
  input  logic [CW-1:0]     lnk_ch,
  input  logic [1:0]        lnk_kind,
  input  logic [CW-1:0]     lnk_tgt,
  input  logic [NCH-1:0]    auto_stop,
  input  logic [NCH-1:0]    ien_major,
  input  logic [NCH-1:0]    ien_half,
  input  logic [NCH-1:0]    ien_err,
  input  logic [NCH-1:0]    sg_en,
  input  logic [NCH*AW-1:0] sg_addr,
  input  logic              evt_vld,
  input  logic [CW-1:0]     evt_ch,
  input  logic              evt_major,
  input  logic [CNT_W-1:0]  evt_citer,
  input  logic [CNT_W-1:0]  evt_biter,
  input  logic              err_vld,
  input  logic [CW-1:0]     err_ch,
  input  logic              sclr_we,
  input  logic [CW-1:0]     sclr_ch,
  input  logic [2:0]        sclr_mask,
  output logic [NCH-1:0]    req_vec,
  output logic [NCH-1:0]    link_pulse,
  output logic [NCH-1:0]    done_flag,
  output logic [NCH-1:0]    err_flag,
  output logic [NCH-1:0]    irq,
  output logic              fetch_vld,
  output logic [CW-1:0]     fetch_ch,
  output logic [AW-1:0]     fetch_addr
);
  logic self_hold;
  logic sg_err;

  dlc_link #(.NCH(NCH), .CW(CW)) u_link (
    .clk(clk), .rst(rst), .cont_mode(cont_mode),
    .cfg_we(lnk_we), .cfg_ch(lnk_ch), .cfg_kind(lnk_kind), .cfg_tgt(lnk_tgt),
    .done_vec(done_flag), .evt_vld(evt_vld), .evt_ch(evt_ch),
    .evt_major(evt_major), .link_pulse(link_pulse), .self_hold(self_hold)
  );

  dlc_req #(.NCH(NCH), .CW(CW)) u_req (
    .clk(clk), .rst(rst), .hw_req(hw_req),
    .set_we(set_req_we), .set_ch(set_req_ch),
    .clr_we(clr_req_we), .clr_ch(clr_req_ch),
    .st_we(swst_we), .st_ch(swst_ch), .link_pulse(link_pulse),
    .evt_vld(evt_vld), .evt_ch(evt_ch), .evt_major(evt_major),
    .auto_stop(auto_stop), .self_hold(self_hold), .req_vec(req_vec)
  );

  dlc_sg #(.NCH(NCH), .CW(CW), .AW(AW), .ALB(ALB)) u_sg (
    .clk(clk), .rst(rst), .evt_vld(evt_vld), .evt_ch(evt_ch),
    .evt_major(evt_major), .sg_en(sg_en), .sg_addr(sg_addr),
    .fetch_vld(fetch_vld), .fetch_ch(fetch_ch), .fetch_addr(fetch_addr),
    .sg_err(sg_err)
  );

  dlc_stat #(.NCH(NCH), .CW(CW), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst), .evt_vld(evt_vld), .evt_ch(evt_ch),
    .evt_major(evt_major), .evt_citer(evt_citer), .evt_biter(evt_biter),
    .err_vld(err_vld), .err_ch(err_ch), .sg_err(sg_err),
    .ien_major(ien_major), .ien_half(ien_half), .ien_err(ien_err),
    .sclr_we(sclr_we), .sclr_ch(sclr_ch), .sclr_mask(sclr_mask),
    .done_vec(done_flag), .err_vec(err_flag), .int_vec(irq)
  );
endmodule

// File: rtl/dlc_chk.sv
module dlc_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int ALB = 5,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           swst_we,
  input logic [CW-1:0]  swst_ch,
  input logic           evt_vld,
  input logic [CW-1:0]  evt_ch,
  input logic           evt_major,
  input logic           err_vld,
  input logic [CW-1:0]  err_ch,
  input logic [NCH-1:0] req_vec,
  input logic [NCH-1:0] link_pulse,
  input logic [NCH-1:0] done_flag,
  input logic [NCH-1:0] err_flag,
  input logic           fetch_vld,
  input logic [AW-1:0]  fetch_addr
);
  p_swstart_r2: assert property (@(posedge clk) disable iff (rst)
    swst_we |=> req_vec[$past(swst_ch)]);

  p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_major) |=> done_flag[$past(evt_ch)]);

  p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> err_flag[$past(err_ch)]);

  p_fetch_align_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> (fetch_addr[ALB-1:0] == '0));

  p_link_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_pulse));

  // R4: a link pulse always follows a loop event
  p_link_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (link_pulse != '0) |-> $past(evt_vld));
endmodule

bind dma_link_ctl dlc_chk #(.NCH(NCH), .AW(AW), .ALB(ALB), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .swst_we(swst_we), .swst_ch(swst_ch),
  .evt_vld(evt_vld), .evt_ch(evt_ch), .evt_major(evt_major),
  .err_vld(err_vld), .err_ch(err_ch), .req_vec(req_vec),
  .link_pulse(link_pulse), .done_flag(done_flag), .err_flag(err_flag),
  .fetch_vld(fetch_vld), .fetch_addr(fetch_addr)
);

// File: tb/dma_link_ctl_test.sv
`timescale 1ns/1ps
module dma_link_ctl_test;
  localparam int NCH = 4, AW = 32, CNT_W = 9, CW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] hw_req = '0, auto_stop = '0, ien_major = '0, ien_half = '0, ien_err = '0, sg_en = '0;
  logic cont_mode = 1'b0;
  logic set_req_we = 0, clr_req_we = 0, swst_we = 0, lnk_we = 0, evt_vld = 0, evt_major = 0;
  logic err_vld = 0, sclr_we = 0;
  logic [CW-1:0] set_req_ch = '0, clr_req_ch = '0, swst_ch = '0, lnk_ch = '0, lnk_tgt = '0;
  logic [CW-1:0] evt_ch = '0, err_ch = '0, sclr_ch = '0;
  logic [1:0] lnk_kind = '0;
  logic [2:0] sclr_mask = '0;
  logic [CNT_W-1:0] evt_citer = '0, evt_biter = '0;
  logic [NCH*AW-1:0] sg_addr = '0;
  logic [NCH-1:0] req_vec, link_pulse, done_flag, err_flag, irq;
  logic fetch_vld;
  logic [CW-1:0] fetch_ch;
  logic [AW-1:0] fetch_addr;

  int checks = 0, errors = 0;
  bit mon_req = 0;
  bit finished = 0;
  int qf[$];
  logic [31:0] qe[$];
  string qt[$];

  always #2.5 clk = ~clk;

  dma_link_ctl #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W)) uut (.*);

  function automatic logic [31:0] field(int f);
    case (f)
      0: field = 32'(req_vec);
      1: field = 32'(link_pulse);
      2: field = 32'(done_flag);
      3: field = 32'(err_flag);
      4: field = 32'(irq);
      5: field = 32'(fetch_vld);
      6: field = fetch_addr;
      default: field = 32'(fetch_ch);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (mon_req == 1'b1);
      while (qf.size() > 0) begin
        int f;
        logic [31:0] e, g;
        string t;
        f = qf.pop_front(); e = qe.pop_front(); t = qt.pop_front();
        g = field(f);
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s field=%0d actual=%h expected=%h", t, f, g, e);
        end
      end
      mon_req = 1'b0;
    end
  end

  task automatic exp(string t, int f, logic [31:0] v);
    qf.push_back(f); qe.push_back(v); qt.push_back(t);
  endtask

  task automatic settle();
    mon_req = 1'b1;
    wait (mon_req == 1'b0);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    set_req_we = 0; clr_req_we = 0; swst_we = 0; lnk_we = 0;
    evt_vld = 0; evt_major = 0; err_vld = 0; sclr_we = 0;
  endtask

  task automatic ev(int ch, bit major, int citer, int biter);
    evt_vld = 1; evt_ch = CW'(ch); evt_major = major;
    evt_citer = CNT_W'(citer); evt_biter = CNT_W'(biter);
    tick();
  endtask

  task automatic lnk(int ch, int kind, int tgt);
    lnk_we = 1; lnk_ch = CW'(ch); lnk_kind = 2'(kind); lnk_tgt = CW'(tgt);
    tick();
  endtask

  task automatic sclr(int ch, int mask);
    sclr_we = 1; sclr_ch = CW'(ch); sclr_mask = 3'(mask);
    tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst = 0;
    tick();
    // R13 reset state
    exp("R13 req", 0, 0); exp("R13 done", 2, 0); exp("R13 err", 3, 0);
    exp("R13 irq", 4, 0); exp("R13 fetch", 5, 0); exp("R13 link", 1, 0);
    settle();

    // R1 request enable
    hw_req = 4'b0010;
    set_req_we = 1; set_req_ch = 1; tick();
    exp("R1 set", 0, 32'h2); settle();
    hw_req = 4'b0110; tick();
    exp("R1 not enabled ch2", 0, 32'h2); settle();
    set_req_we = 1; set_req_ch = 1; clr_req_we = 1; clr_req_ch = 1; tick();
    exp("R1 clear wins", 0, 32'h0); settle();
    set_req_we = 1; set_req_ch = 1; tick();
    exp("R1 reset", 0, 32'h2); settle();
    hw_req = 4'b0000; tick();
    exp("R1 hw low", 0, 32'h0); settle();

    // R2 software start
    swst_we = 1; swst_ch = 3; tick();
    exp("R2 start", 0, 32'h8); settle();
    tick();
    exp("R2 holds", 0, 32'h8); settle();
    ev(3, 0, 5, 8);
    exp("R2 consumed", 0, 32'h0); exp("R2 irq", 4, 0); settle();

    // R3 minor link ch0 -> ch2
    lnk(0, 1, 2);
    ev(0, 0, 3, 8);
    exp("R3 pulse", 1, 32'h4); exp("R3 req early", 0, 0); settle();
    tick();
    exp("R3 pulse gone", 1, 0); exp("R3 target req", 0, 32'h4); settle();
    ev(2, 0, 7, 8);
    exp("R3 target consumed", 0, 0); settle();
    // final event with clear in same cycle: R12 set wins; R3 no minor fire
    evt_vld = 1; evt_ch = 0; evt_major = 1; evt_citer = 0; evt_biter = 8;
    sclr_we = 1; sclr_ch = 0; sclr_mask = 3'b001; tick();
    exp("R3 no minor on final", 1, 0); exp("R7/R12 done set wins", 2, 32'h1); settle();
    // R11 write while done is ignored
    lnk(0, 2, 1);
    ev(0, 1, 0, 8);
    exp("R11 cfg ignored", 1, 0); settle();
    sclr(0, 1);
    exp("R12 done cleared", 2, 0); settle();
    lnk(0, 2, 1);
    ev(0, 0, 2, 4);
    exp("R4 no major on minor", 1, 0); exp("R8 half disabled", 4, 0); settle();
    ev(0, 1, 0, 4);
    exp("R4 major pulse", 1, 32'h2); exp("R7 done", 2, 32'h1); settle();
    tick();
    exp("R4 target req", 0, 32'h2); settle();
    ev(1, 0, 1, 1);
    exp("R4 target consumed", 0, 0); settle();
    sclr(0, 1);

    // R5 continuous self link
    cont_mode = 1;
    lnk(3, 1, 3);
    swst_we = 1; swst_ch = 3; tick();
    exp("R5 start", 0, 32'h8); settle();
    ev(3, 0, 4, 9);
    exp("R5 no gap", 0, 32'h8); exp("R5 no pulse", 1, 0); settle();
    tick();
    exp("R5 still", 0, 32'h8); settle();
    cont_mode = 0;
    ev(3, 0, 3, 9);
    exp("R5 gap", 0, 0); exp("R5 self pulse", 1, 32'h8); settle();
    tick();
    exp("R5 relaunch", 0, 32'h8); settle();
    lnk(3, 0, 0);
    ev(3, 0, 2, 9);
    exp("R5 stop", 0, 0); exp("R5 stop pulse", 1, 0); settle();

    // R6 auto-stop (ch1 enable still set)
    hw_req = 4'b0010; auto_stop = 4'b0010; tick();
    exp("R6 before", 0, 32'h2); settle();
    ev(1, 1, 0, 4);
    exp("R6 cleared", 0, 0); exp("R7 done ch1", 2, 32'h2); settle();
    tick();
    exp("R6 stays off", 0, 0); settle();
    hw_req = 0; auto_stop = 0;
    sclr(1, 1);

    // R8 interrupts
    ien_major[2] = 1; ien_half[2] = 1;
    ev(2, 0, 4, 6);
    exp("R8 not half", 4, 0); settle();
    ev(2, 0, 3, 6);
    exp("R8 half even", 4, 32'h4); settle();
    sclr(2, 4);
    exp("R12 int cleared", 4, 0); settle();
    ev(2, 0, 2, 5);
    exp("R8 half odd", 4, 32'h4); settle();
    sclr(2, 4);
    ev(2, 1, 0, 5);
    exp("R8 major", 4, 32'h4); exp("R7 done ch2", 2, 32'h4); settle();
    sclr(2, 5);
    exp("R12 both cleared", 4, 0); exp("R12 done2", 2, 0); settle();
    ien_major = 0; ien_half = 0;

    // R9 error events
    err_vld = 1; err_ch = 1; tick();
    exp("R9 err", 3, 32'h2); exp("R9 no irq", 4, 0); settle();
    sclr(1, 2);
    ien_err[1] = 1;
    err_vld = 1; err_ch = 1; tick();
    exp("R9 err irq", 3, 32'h2); exp("R9 irq", 4, 32'h2); settle();
    sclr(1, 6);
    exp("R12 err cleared", 3, 0); settle();
    ien_err = 0;

    // R10 descriptor chaining
    lnk(0, 0, 0);
    sg_en[0] = 1; sg_addr[0 +: AW] = 32'h2000_0040;
    ev(0, 1, 0, 3);
    exp("R10 fetch", 5, 1); exp("R10 addr", 6, 32'h2000_0040);
    exp("R10 ch", 7, 0); exp("R10 no err", 3, 0); settle();
    tick();
    exp("R10 single pulse", 5, 0); settle();
    sclr(0, 1);
    sg_addr[0 +: AW] = 32'h2000_0044;
    ev(0, 1, 0, 3);
    exp("R10 misaligned no fetch", 5, 0); exp("R10 sg err", 3, 32'h1); settle();
    sclr(0, 3);
    exp("R12 clear all", 3, 0); settle();

    finished = 1;
    summary();
    $finish;
  end
endmodule